// File: doc/BRIEF.md
# Link Initialization Recovery Sequencer

This block supervises bring-up of a serial port that can run either as a single-lane (1x) link or as a four-lane (4x) link. After a start pulse it checks that the SERDES has finished its reset. It then waits a bounded time for the port to report itself initialized, and accepts the link only if it came up at the width it was configured for. A 4x port that trained down to one lane is treated as a failure, just like a port that never came up.

When the check fails, the block runs a timed recovery attempt. It takes the port offline, discards outbound traffic, pulses the receiver resets of the lanes in use and clears the port's latched status. It then brings the port back and waits for the link to retrain before checking again. After three unsuccessful attempts the block gives up. Once the link is accepted, the block waits for the port's output-error-stopped condition to clear, issues a final status clear and reports completion.

All waits are counted in clock cycles derived from a clock-frequency parameter. A divisor parameter shrinks every wait uniformly for short simulation builds. The SERDES, lane alignment and any register access are outside the block and appear only as plain inputs and outputs.

Top module: `link_init_recovery`

## Requirements
- R1: If `serdes_ready` is low when a start is accepted, `fail` is high on the next cycle and no recovery is attempted.
- R2: After a start with `serdes_ready` high, the block waits up to 2 ms for `port_up`. If `port_up` stays low for the whole window, a recovery attempt begins.
- R3: With `cfg_wide` low (1x), `port_up` high is accepted whatever `up_width` reads.
- R4: With `cfg_wide` high (4x), `port_up` is accepted only when `up_width` equals 3'b010. Any other code starts a recovery attempt.
- R5: At most three recovery attempts are made. If the check after the third attempt fails, `fail` is raised.
- R6: Each attempt raises `port_off`, then `drop_out`, then waits 50 us. It then holds the active receiver resets low for at least 100 ns and waits at least 300 ns after releasing them. The receiver resets are low only while `port_off` and `drop_out` are both high, and are high at all other times.
- R7: The active lanes are bit 0 of `lane_rx_rst_n` alone for 1x, and bits 3:0 for 4x.
- R8: After the reset pulse, `stat_clear` pulses for exactly one cycle while the port is still disabled and discarding. `drop_out` falls next, then `port_off` falls. The block then waits at least 24 ms before checking the link again, so successive reset pulses are at least 24 ms apart.
- R9: Once the link is accepted, the block waits up to 1 s for `out_err_stop` to be low. On timeout it raises `fail` without issuing a final status clear.
- R10: When `out_err_stop` reads low on the success path, `stat_clear` pulses once and `done` rises.
- R11: Reset leaves all outputs inactive, with `lane_rx_rst_n` all ones. `done` and `fail` are never high together, and each stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence; honoured when idle, done or failed |
| serdes_ready | input | 1 | SERDES reset has completed |
| port_up | input | 1 | Port reports initialization complete |
| up_width | input | 3 | Width code the port trained to (3'b010 = four lanes) |
| cfg_wide | input | 1 | Configured width: 1 = 4x, 0 = 1x; sampled at start |
| out_err_stop | input | 1 | Port is in the output-error-stopped condition |
| port_off | output | 1 | Port disable control |
| drop_out | output | 1 | Discard pending outbound packets |
| lane_rx_rst_n | output | LANES | Active-low receiver reset per lane |
| stat_clear | output | 1 | One-cycle pulse clearing the port's latched status |
| done | output | 1 | Link initialized at the configured width |
| fail | output | 1 | Initialization could not be achieved |

## Verification
The assertions assume that `start` is a single-cycle pulse and that `cfg_wide` does not change while a sequence runs, because the block samples it only at start. They also assume that `port_up`, `up_width` and `out_err_stop` are synchronous to `clk`. The bench models the port as a small state machine that changes these inputs only half a cycle after an edge. It raises `port_up` only after a chosen number of completed receiver-reset pulses, or reports a trained-down width until then. It holds `cfg_wide` fixed from one start to the next.

// File: rtl/link_init_recovery.sv
module link_init_recovery #(
  parameter longint CLK_HZ    = 100_000_000,
  parameter int     TIME_DIV  = 1,
  parameter int     MAX_TRIES = 3,
  parameter int     LANES     = 4,
  parameter logic [2:0] WIDE_CODE = 3'b010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             serdes_ready,
  input  logic             port_up,
  input  logic [2:0]       up_width,
  input  logic             cfg_wide,
  input  logic             out_err_stop,
  output logic             port_off,
  output logic             drop_out,
  output logic [LANES-1:0] lane_rx_rst_n,
  output logic             stat_clear,
  output logic             done,
  output logic             fail
);

  function automatic longint cyc(input longint ns);
    longint den, c;
    den = longint'(TIME_DIV) * 64'd1_000_000_000;
    c = (CLK_HZ * ns + den - 1) / den;
    return (c < 1) ? 64'd1 : c;
  endfunction

  localparam longint T_POLL   = cyc(64'd2_000_000);
  localparam longint T_QUIET  = cyc(64'd50_000);
  localparam longint T_LOW    = cyc(64'd100);
  localparam longint T_SET    = cyc(64'd300);
  localparam longint T_SETTLE = cyc(64'd24_000_000);
  localparam longint T_OES    = cyc(64'd1_000_000_000);
  localparam int CW = $clog2(T_OES + 1);
  localparam int TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_OFF, S_DROP, S_QUIET, S_LOW, S_SET, S_CLR,
    S_KEEP, S_SETTLE, S_CHECK, S_OES, S_FINAL, S_DONE, S_FAIL
  } state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tries;
  logic           wide_q;
  logic           busy, good;
  logic [LANES-1:0] mask;

  assign busy = !(st inside {S_IDLE, S_DONE, S_FAIL});
  assign good = port_up && (!wide_q || up_width == WIDE_CODE);
  assign mask = wide_q ? '1 : LANES'(1);

  assign port_off      = st inside {S_OFF, S_DROP, S_QUIET, S_LOW, S_SET, S_CLR, S_KEEP};
  assign drop_out      = st inside {S_DROP, S_QUIET, S_LOW, S_SET, S_CLR};
  assign lane_rx_rst_n = (st == S_LOW) ? ~mask : '1;
  assign stat_clear    = (st == S_CLR) || (st == S_FINAL);
  assign done          = (st == S_DONE);
  assign fail          = (st == S_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tries  <= '0;
      wide_q <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (st)
        S_IDLE, S_DONE, S_FAIL:
          if (start) begin
            wide_q <= cfg_wide;
            tries  <= '0;
            if (!serdes_ready) st <= S_FAIL;
            else begin
              st  <= S_POLL;
              cnt <= CW'(T_POLL - 1);
            end
          end
        S_POLL:
          if (port_up) begin
            if (good) begin
              st  <= S_OES;
              cnt <= CW'(T_OES - 1);
            end else st <= S_OFF;
          end else if (cnt == '0) st <= S_OFF;
        S_OFF:  st <= S_DROP;
        S_DROP: begin
          st  <= S_QUIET;
          cnt <= CW'(T_QUIET - 1);
        end
        S_QUIET:
          if (cnt == '0) begin
            st  <= S_LOW;
            cnt <= CW'(T_LOW - 1);
          end
        S_LOW:
          if (cnt == '0) begin
            st  <= S_SET;
            cnt <= CW'(T_SET - 1);
          end
        S_SET:  if (cnt == '0) st <= S_CLR;
        S_CLR:  st <= S_KEEP;
        S_KEEP: begin
          st  <= S_SETTLE;
          cnt <= CW'(T_SETTLE - 1);
        end
        S_SETTLE: if (cnt == '0) st <= S_CHECK;
        S_CHECK:
          if (good) begin
            st  <= S_OES;
            cnt <= CW'(T_OES - 1);
          end else if (tries == TW'(MAX_TRIES - 1)) st <= S_FAIL;
          else begin
            tries <= tries + 1'b1;
            st    <= S_OFF;
          end
        S_OES:
          if (!out_err_stop) st <= S_FINAL;
          else if (cnt == '0) st <= S_FAIL;
        S_FINAL: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cold_serdes_fails_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !serdes_ready) |=> fail)
    else $error("serdes not ready but no fail");

  assert_narrow_link_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_POLL || st == S_CHECK) && port_up && wide_q && up_width != WIDE_CODE)
      |=> (port_off || fail))
    else $error("trained-down 4x link accepted");

  assert_reset_only_when_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_rx_rst_n != '1) |-> (port_off && drop_out))
    else $error("receiver reset outside disabled window");

  assert_single_lane_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_q && lane_rx_rst_n != '1) |-> (lane_rx_rst_n[LANES-1:1] == '1))
    else $error("upper lanes reset in 1x mode");

  assert_clear_is_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clear |=> !stat_clear)
    else $error("status clear longer than one cycle");

  assert_discard_drops_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drop_out) |-> port_off)
    else $error("port enabled before discard cleared");

  assert_done_fail_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail))
    else $error("done and fail together");

  assert_done_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done)
    else $error("done dropped without start");

  assert_fail_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail)
    else $error("fail dropped without start");

endmodule

// File: tb/sim_link_init_recovery.sv
module sim_link_init_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int HZ        = 10_000_000;
  localparam int DIV       = 1000;
  localparam int W_POLL    = HZ / 500 / DIV;
  localparam int W_SETTLE  = HZ / 1000 * 24 / DIV;
  localparam int W_OES     = HZ / DIV;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic serdes_ready = 1'b1, cfg_wide = 1'b0;
  logic port_up, out_err_stop;
  logic [2:0] up_width;
  logic port_off, drop_out, stat_clear, done, fail;
  logic [3:0] lane_rx_rst_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_init_recovery #(.CLK_HZ(HZ), .TIME_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .serdes_ready(serdes_ready),
    .port_up(port_up), .up_width(up_width), .cfg_wide(cfg_wide),
    .out_err_stop(out_err_stop), .port_off(port_off), .drop_out(drop_out),
    .lane_rx_rst_n(lane_rx_rst_n), .stat_clear(stat_clear), .done(done), .fail(fail));

  int n_cmp = 0, n_bad = 0;
  int good_after = 0, oes_cfg = 0;
  bit trained_down = 0, oes_stuck = 0;

  int pulses, clr_cnt, viol, gap_bad, cyc, start_cyc, first_off, last_pulse, oes_left;
  logic [3:0] low_seen;
  logic prev_low, prev_drop, prev_off;

  always_comb begin
    port_up      = (pulses >= good_after) || trained_down;
    up_width     = (pulses >= good_after) ? 3'b010 : 3'b001;
    out_err_stop = oes_stuck || (oes_left > 0);
  end

  always @(negedge clk) begin
    cyc++;
    if (start) begin
      pulses = 0; clr_cnt = 0; viol = 0; gap_bad = 0; low_seen = 0;
      start_cyc = cyc; first_off = -1; last_pulse = -1; oes_left = oes_cfg;
    end else begin
      if (oes_left > 0) oes_left--;
      if (lane_rx_rst_n != 4'hF) begin
        low_seen |= ~lane_rx_rst_n;
        if (!(port_off && drop_out)) viol++;
      end
      if (prev_low && lane_rx_rst_n == 4'hF) begin
        if (last_pulse >= 0 && cyc - last_pulse < W_SETTLE) gap_bad++;
        last_pulse = cyc;
        pulses++;
      end
      if (stat_clear) begin
        clr_cnt++;
        if (port_off && !drop_out) viol++;
      end
      if (prev_drop && !drop_out && !port_off) viol++;
      if (!prev_off && port_off && first_off < 0) first_off = cyc - start_cyc;
    end
    prev_low  = (lane_rx_rst_n != 4'hF);
    prev_drop = drop_out;
    prev_off  = port_off;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int wcount;
  task automatic run(input bit rd, input bit wide, input int ga, input bit td,
                     input int oes_n, input bit stuck);
    @(negedge clk); #1;
    serdes_ready = rd; cfg_wide = wide; good_after = ga; trained_down = td;
    oes_cfg = oes_n; oes_stuck = stuck; start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    wcount = 0;
    while (!(done || fail) && wcount < 30000) begin
      @(negedge clk); wcount++;
    end
  endtask

  // {serdes_ready, cfg_wide, good_after, trained_down, exp_done, exp_pulses, exp_lanes}
  localparam int NV = 8;
  localparam int VEC [NV][7] = '{
    '{1, 1, 0, 0, 1, 0, 0},
    '{1, 0, 0, 0, 1, 0, 0},
    '{1, 1, 1, 1, 1, 1, 15},
    '{1, 0, 2, 0, 1, 2, 1},
    '{1, 1, 3, 0, 1, 3, 15},
    '{1, 1, 9, 1, 0, 3, 15},
    '{1, 0, 9, 1, 1, 0, 0},
    '{0, 1, 0, 0, 0, 0, 0}
  };
  string vtag [NV] = '{"R4 4x clean", "R3 1x clean", "R4 4x trained down",
                       "R2 R7 1x poll timeout", "R5 third try ok", "R5 exhaust",
                       "R3 1x ignores width", "R1 serdes not ready"};

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset fail", fail, 0);
    chk("R11 reset port_off", port_off, 0);
    chk("R11 reset drop_out", drop_out, 0);
    chk("R11 reset rx", lane_rx_rst_n, 15);
    chk("R11 reset clear", stat_clear, 0);
    #1 rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      run(VEC[v][0][0], VEC[v][1][0], VEC[v][2], VEC[v][3][0], 0, 0);
      chk({vtag[v], " done"}, done, VEC[v][4]);
      chk({vtag[v], " fail R11"}, fail, 1 - VEC[v][4]);
      chk({vtag[v], " pulses R5"}, pulses, VEC[v][5]);
      chk({vtag[v], " lanes R7"}, low_seen, VEC[v][6]);
      chk({vtag[v], " clears R8 R10"}, clr_cnt, VEC[v][5] + VEC[v][4]);
      chk({vtag[v], " order R6 R8"}, viol, 0);
      chk({vtag[v], " settle gap R8"}, gap_bad, 0);
      if (VEC[v][0] == 0) chk("R1 fail next cycle", wcount, 0);
      if (VEC[v][3] == 0 && VEC[v][2] > 0)
        chk("R2 poll window", (first_off >= W_POLL && first_off <= W_POLL + 3) ? 1 : 0, 1);
    end

    run(1, 1, 0, 0, 0, 0);
    repeat (50) @(negedge clk);
    chk("R11 done held", done, 1);
    chk("R11 fail low while done", fail, 0);

    run(1, 1, 0, 0, 100, 0);
    chk("R10 done after late oes clear", done, 1);
    chk("R10 waited for oes", (wcount >= 100) ? 1 : 0, 1);
    chk("R10 final clear", clr_cnt, 1);

    run(1, 0, 0, 0, 0, 1);
    chk("R9 oes timeout fail", fail, 1);
    chk("R9 no final clear", clr_cnt, 0);
    chk("R9 timeout length", (wcount >= W_OES) ? 1 : 0, 1);
    repeat (20) @(negedge clk);
    chk("R11 fail held", fail, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule